// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory-Bus Master

This block sits inside a synchronous clock domain and turns single-word read and write requests into asynchronous SRAM-style cycles on an external port. The port carries a 16-bit shared address/data path, an active-low chip select, an active-low address-valid strobe, an active-low read strobe and an active-low write strobe. Each cycle has three parts. First an address phase, in which chip select and address-valid fall and the halfword address is driven. Then an optional address-hold phase. Then a data phase, in which exactly one data strobe is held low. An optional turnaround gap can follow.

Requests carry a byte address. Because the port is a halfword port, bit 0 of the byte address is dropped and the remaining bits are placed on the shared lines. All phase lengths are parameters counted in controller clocks. The defaults are an address phase of 1 clock, no hold, a data phase of 4 clocks and no turnaround. Reads and writes share this timing.

The shared lines are split at this boundary into an output value, an output enable and an input value. The pad ring combines them into a bidirectional pin, where a low enable leaves the pin in high impedance. A request is taken only while `ready_o` is high. Completion is reported by a one-clock `done_o`. Read data stays on `rdata_o` until the next read completes.

Top module: `mbm_top`

## Requirements
- R1: Whenever `rst_ni` is low, the outputs take the idle state at once, without waiting for a clock. In the idle state `cs_no`, `adv_no`, `oe_no` and `we_no` are 1, `ad_oe_o` is 0, `done_o` is 0 and `ready_o` is 1.
- R2: In the clock after a request is accepted (`req_valid_i` and `ready_o` both high at an edge), the following hold for ADDR_SETUP clocks (default 1): `cs_no` and `adv_no` are 0, `ad_oe_o` is 1, `ad_o` carries the address, and both data strobes are 1.
- R3: The address placed on `ad_o` is the byte address shifted right by one bit. Bit 0 of `req_addr_i` has no effect.
- R4: For a write, the data phase follows the address phase and lasts DATA_SETUP clocks (default 4). During it `adv_no` is 1, `cs_no` is 0, `we_no` is 0, `ad_oe_o` is 1 and `ad_o` equals the accepted write data.
- R5: For a read, the data phase lasts DATA_SETUP clocks. During it `oe_no` is 0 and `ad_oe_o` is 0, so the lines are released. `rdata_o` takes the value of `ad_i` present in the last data clock, just before `oe_no` rises. A write leaves `rdata_o` unchanged.
- R6: In the clock right after the data phase, `done_o` is 1 for exactly one clock. In that clock `cs_no` and both strobes are 1 and `ready_o` is 1.
- R7: While a cycle is in progress `ready_o` is 0, and requests presented then have no effect on the bus or on the cycle in progress.
- R8: With zero turnaround, a request presented in the `done_o` clock is accepted at once. `cs_no` is then high for exactly one clock between the two cycles.
- R9: `we_no` and `oe_no` are never both 0. `adv_no` is 0 only while `cs_no` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (17) | Byte address |
| req_wdata_i | input | DATA_W (16) | Write data |
| ready_o | output | 1 | Controller idle, request can be taken |
| rdata_o | output | DATA_W (16) | Last read data |
| done_o | output | 1 | One-clock completion pulse |
| cs_no | output | 1 | Chip select, active low |
| adv_no | output | 1 | Address-valid strobe, active low |
| oe_no | output | 1 | Read strobe, active low |
| we_no | output | 1 | Write strobe, active low |
| ad_o | output | DATA_W (16) | Shared address/data value driven out |
| ad_oe_o | output | 1 | Drive enable for the shared lines; 0 = high impedance |
| ad_i | input | DATA_W (16) | Shared lines as seen from the pad |

## Verification
Two events can land in the same clock edge: the completion pulse of one cycle and the acceptance of the next request. The bench provokes this by presenting a new request in the `done_o` clock, both in a directed back-to-back pair and in random runs with zero gap. It then checks that `cs_no` rises for exactly one clock and that the new address, not stale data, appears. Requests are also held high throughout busy cycles, carrying different addresses and data. This shows they cannot be taken early and cannot corrupt the driven data. The read model changes `ad_i` on every strobe clock, so a sample taken one clock early or late returns a different value.

// File: rtl/mbm_pkg.sv
`timescale 1ns/1ps
package mbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_DATA = 3'd3,
    ST_TURN = 3'd4
  } mbm_state_e;
endpackage

// File: rtl/mbm_seq.sv
`timescale 1ns/1ps
module mbm_seq
  import mbm_pkg::*;
#(
  parameter int ADDR_SETUP = 1,
  parameter int ADDR_HOLD  = 0,
  parameter int DATA_SETUP = 4,
  parameter int TURNAROUND = 0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output mbm_state_e state_q_o,
  output mbm_state_e state_d_o,
  output logic       last_data_o
);
  localparam int MAX_AB  = (ADDR_SETUP > ADDR_HOLD) ? ADDR_SETUP : ADDR_HOLD;
  localparam int MAX_DT  = (DATA_SETUP > TURNAROUND) ? DATA_SETUP : TURNAROUND;
  localparam int MAX_LEN = (MAX_AB > MAX_DT) ? MAX_AB : MAX_DT;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  localparam logic [CNT_W-1:0] LD_ADDR = CNT_W'(ADDR_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = (ADDR_HOLD > 0) ? CNT_W'(ADDR_HOLD - 1) : '0;
  localparam logic [CNT_W-1:0] LD_DATA = CNT_W'(DATA_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_TURN = (TURNAROUND > 0) ? CNT_W'(TURNAROUND - 1) : '0;

  mbm_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_i) begin
          state_d = ST_ADDR;
          cnt_d   = LD_ADDR;
        end
      end
      ST_ADDR: if (cnt_zero) begin
        if (ADDR_HOLD > 0) begin
          state_d = ST_HOLD;
          cnt_d   = LD_HOLD;
        end else begin
          state_d = ST_DATA;
          cnt_d   = LD_DATA;
        end
      end
      ST_HOLD: if (cnt_zero) begin
        state_d = ST_DATA;
        cnt_d   = LD_DATA;
      end
      ST_DATA: if (cnt_zero) begin
        if (TURNAROUND > 0) begin
          state_d = ST_TURN;
          cnt_d   = LD_TURN;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_TURN: if (cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_q_o   = state_q;
  assign state_d_o   = state_d;
  assign last_data_o = (state_q == ST_DATA) && cnt_zero;

  // R7: a cycle only starts from idle
  p_start_from_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && $past(state_q) != ST_ADDR) |-> $past(state_q) == ST_IDLE);
  // R5/R4: data phase is always entered from the address side
  p_data_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) != ST_DATA) |->
      ($past(state_q) == ST_ADDR || $past(state_q) == ST_HOLD));
endmodule

// File: rtl/mbm_pins.sv
`timescale 1ns/1ps
module mbm_pins
  import mbm_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mbm_state_e        state_d_i,
  input  logic              accept_i,
  input  logic              last_data_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              cs_no,
  output logic              adv_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic              wr_q;
  logic [DATA_W-1:0] haddr_q, wdata_q;
  logic              cur_wr;
  logic [DATA_W-1:0] cur_haddr, cur_wdata;

  // halfword port: drop byte-lane bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      haddr_q <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      wr_q    <= req_write_i;
      haddr_q <= DATA_W'(req_addr_i >> 1);
      wdata_q <= req_wdata_i;
    end
  end

  assign cur_wr    = accept_i ? req_write_i : wr_q;
  assign cur_haddr = accept_i ? DATA_W'(req_addr_i >> 1) : haddr_q;
  assign cur_wdata = accept_i ? req_wdata_i : wdata_q;

  // pins registered from next state: glitch-free at the pads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_no   <= 1'b1;
      adv_no  <= 1'b1;
      oe_no   <= 1'b1;
      we_no   <= 1'b1;
      ad_o    <= '0;
      ad_oe_o <= 1'b0;
    end else begin
      cs_no   <= 1'b1;
      adv_no  <= 1'b1;
      oe_no   <= 1'b1;
      we_no   <= 1'b1;
      ad_o    <= '0;
      ad_oe_o <= 1'b0;
      unique case (state_d_i)
        ST_ADDR: begin
          cs_no   <= 1'b0;
          adv_no  <= 1'b0;
          ad_o    <= cur_haddr;
          ad_oe_o <= 1'b1;
        end
        ST_HOLD: begin
          cs_no   <= 1'b0;
          ad_o    <= cur_haddr;
          ad_oe_o <= 1'b1;
        end
        ST_DATA: begin
          cs_no <= 1'b0;
          if (cur_wr) begin
            we_no   <= 1'b0;
            ad_o    <= cur_wdata;
            ad_oe_o <= 1'b1;
          end else begin
            oe_no <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= last_data_i;
      if (last_data_i && !wr_q) rdata_o <= ad_i;
    end
  end

  p_adv_in_cs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_no |-> !cs_no);
  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no);
  p_read_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> !ad_oe_o);
  p_write_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> ad_oe_o);
  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && we_no && oe_no && ($past(!oe_no) || $past(!we_no))));
endmodule

// File: rtl/mbm_top.sv
`timescale 1ns/1ps
module mbm_top
  import mbm_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 16,
  parameter int ADDR_SETUP = 1,
  parameter int ADDR_HOLD  = 0,
  parameter int DATA_SETUP = 4,
  parameter int TURNAROUND = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              cs_no,
  output logic              adv_no,
  output logic              oe_no,
  output logic              we_no,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i
);
  mbm_state_e state_q, state_d;
  logic       last_data, accept;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = req_valid_i && ready_o;

  mbm_seq #(
    .ADDR_SETUP(ADDR_SETUP),
    .ADDR_HOLD (ADDR_HOLD),
    .DATA_SETUP(DATA_SETUP),
    .TURNAROUND(TURNAROUND)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .last_data_o(last_data)
  );

  mbm_pins #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_d_i  (state_d),
    .accept_i   (accept),
    .last_data_i(last_data),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .ad_i       (ad_i),
    .cs_no      (cs_no),
    .adv_no     (adv_no),
    .oe_no      (oe_no),
    .we_no      (we_no),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .rdata_o    (rdata_o),
    .done_o     (done_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cs_no && adv_no && oe_no && we_no && !ad_oe_o));
  p_busy_not_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no) |-> !ready_o);
endmodule

// File: tb/mbm_top_tb.sv
`timescale 1ns/1ps
module mbm_top_tb;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;
  localparam int DSETUP = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              ready, done, cs_n, adv_n, oe_n, we_n, ad_oe;
  logic [DATA_W-1:0] rdata, ad_o;
  logic [DATA_W-1:0] ad_i = 16'hDEAD;
  logic [DATA_W-1:0] rd_pat = '0;
  logic [DATA_W-1:0] last_rd = '0;
  int                k = 0;
  int                n_tests = 0, n_fail = 0;
  bit                finished = 1'b0;

  always #4 clk = ~clk;

  mbm_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ready_o(ready), .rdata_o(rdata),
    .done_o(done), .cs_no(cs_n), .adv_no(adv_n), .oe_no(oe_n), .we_no(we_n),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i)
  );

  // slave: new value each read-strobe clock, junk otherwise
  always @(negedge clk) begin
    if (!oe_n) begin
      ad_i <= rd_pat + DATA_W'(k);
      k    <= k + 1;
    end else begin
      ad_i <= 16'hDEAD;
      k    <= 0;
    end
  end

  function automatic logic [DATA_W-1:0] haddr_of(logic [ADDR_W-1:0] a);
    return DATA_W'(a >> 1);
  endfunction
  function automatic logic [DATA_W-1:0] rd_expect(logic [DATA_W-1:0] p);
    return p + DATA_W'(DSETUP - 1);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(cs_n && adv_n && oe_n && we_n, req, {cs_n, adv_n, oe_n, we_n}, 4'hF);
    chk(!ad_oe, req, ad_oe, 0);
    chk(!done, req, done, 0);
  endtask

  // caller sits at a negedge; returns at the done-clock negedge
  task automatic run(bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d,
                     logic [DATA_W-1:0] pat, bit noise, string atag);
    rd_pat    = pat;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    chk(ready, "R7 ready before accept", ready, 1);
    @(negedge clk);
    if (noise) begin
      req_write = ~w; req_addr = ADDR_W'($urandom); req_wdata = DATA_W'($urandom);
    end else req_valid = 1'b0;
    chk(!cs_n && !adv_n && oe_n && we_n, atag, {cs_n, adv_n, oe_n, we_n}, 4'h3);
    chk(ad_oe && ad_o == haddr_of(a), "R3 halfword address", ad_o, haddr_of(a));
    chk(!ready, "R7 busy", ready, 0);
    for (int i = 0; i < DSETUP; i++) begin
      @(negedge clk);
      if (noise) req_addr = ADDR_W'($urandom);
      chk(adv_n && !cs_n && !done, "R4/R5 data phase ctl", {adv_n, cs_n, done}, 3'b100);
      if (w) begin
        chk(!we_n && oe_n, "R9 write strobe only", {we_n, oe_n}, 2'b01);
        chk(ad_oe && ad_o == d, "R4 write data", ad_o, d);
      end else begin
        chk(!oe_n && we_n, "R9 read strobe only", {oe_n, we_n}, 2'b01);
        chk(!ad_oe, "R5 bus released", ad_oe, 0);
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && ready && cs_n && oe_n && we_n, "R6 done clock",
        {done, ready, cs_n, oe_n, we_n}, 5'h1F);
    if (!w) last_rd = rd_expect(pat);
    chk(rdata == last_rd, w ? "R5 write keeps rdata" : "R5 read sample", rdata, last_rd);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    chk_idle("R1 in reset");
    chk(ready, "R1 ready in reset", ready, 1);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");

    // directed: odd byte address, top address, back-to-back pair
    run(1'b1, 17'h00001, 16'hA5A5, 16'h0, 1'b0, "R2 addr phase");
    @(negedge clk);
    chk_idle("R6 single done pulse");
    run(1'b0, 17'h1FFFF, 16'h0, 16'h1230, 1'b0, "R2 addr phase");
    run(1'b1, 17'h0ABCD, 16'h5A5A, 16'h0, 1'b0, "R8 back-to-back accept");
    run(1'b0, 17'h00002, 16'h0, 16'h7770, 1'b0, "R8 back-to-back accept");
    @(negedge clk);
    chk_idle("R8 gap idle");

    // noise while busy must not start a cycle
    run(1'b1, 17'h04444, 16'hC3C3, 16'h0, 1'b1, "R2 addr phase");
    @(negedge clk);
    chk_idle("R7 busy request ignored");

    // async reset mid data phase
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00100;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b0; #1;
    chk_idle("R1 async reset");
    chk(ready, "R1 ready after async reset", ready, 1);
    @(negedge clk); rst_ni = 1'b1; last_rd = '0;
    @(negedge clk);
    chk_idle("R1 after release");

    for (int n = 0; n < 60; n++) begin
      int gap;
      run(bit'($urandom % 2), ADDR_W'($urandom), DATA_W'($urandom),
          DATA_W'($urandom), ($urandom % 3) == 0, "R2 addr phase");
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk_idle("R7 idle gap");
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule